// File: doc/BRIEF.md
# Sixty-Four Source Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents one interrupt request to a processor. Each source has an enable bit and a 4-bit priority level. Software reaches these through a small synchronous register port with 64-bit aligned offsets. Enable bits change only through separate write-one-to-set and write-one-to-clear addresses. A single control bit, the line-mode bit, is handled the same way through its own set and clear addresses.

Every clock the block registers the source lines. It forms the pending view: a line counts as pending when its sampled level is high, it is enabled, its priority is nonzero, and it owns an event vector. The block then selects the pending source with the highest priority. It registers that source's level and event code, and raises the request only when the level exceeds the processor's current mask level.

Top module: `prio_intc`

## Requirements
- R1: After reset the following are all zero: every enable bit, every priority field, the line-mode bit and the request output.
- R2: Offsets 0x70 and 0x78 are enable-set addresses. 0x70 covers sources 0–31 and 0x78 covers sources 32–63, each source at bit (source mod 32). Writing a 1 sets that enable bit and writing a 0 leaves it unchanged. Reading either address returns the current enable bits.
- R3: Offsets 0x80 and 0x88 clear the matching enable bits where the written data is 1. Reads of 0x00, 0x08, 0x80 and 0x88 return zero.
- R4: Priority register n is at offset 0x10+8·n, for n from 0 to 7. Source i sits in register i/8 at bits 4·(i mod 8)+3 down to 4·(i mod 8). These registers read back as written.
- R5: Writing data bit 0 as 1 to offset 0x00 sets the line-mode bit, and writing it as 1 to 0x08 clears it. Writing a 0 in bit 0 has no effect. The bit appears on `line_mode_o`.
- R6: Offsets 0x50 and 0x58 return the source lines as sampled at the previous clock edge, in the bank layout of R2.
- R7: Offsets 0x60 and 0x68 return the pending view. A bit is 1 only when all of these hold: the sampled line is high, the enable bit is set, the priority is nonzero, and the source has a vector.
- R8: Among pending sources the highest priority wins, and ties go to the lowest index. `irq_lvl_o` and `irq_code_o` show the winner's priority and its vector times 0x20, registered one clock after the pending view. Vectors: sources 0–3 use 0x12, 0x15, 0x18, 0x1B; 4–7 use 0x40–0x43; 12–17 use 0x50–0x55; 18–22 use 0x32–0x36; 32–38 use 0x20–0x26; 39–42 use 0x38–0x3B; 63 uses 0x2B.
- R9: `irq_o` is high only when the winning priority is strictly greater than `mask_lvl_i`, evaluated at the same clock edge.
- R10: Sources with no vector never become pending and never win. These are 8–11, 23–31 and 43–62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Level-sensitive source lines |
| mask_lvl_i | input | 4 | Processor mask level |
| addr_i | input | 8 | Register byte offset, 64-bit aligned |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| line_mode_o | output | 1 | Line-mode control bit |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 4 | Winning priority level |
| irq_code_o | output | 12 | Winning event code |

## Verification
Arbitration is tried with several kinds of input pattern:
- A lone high-priority source in the upper bank shows that the bank split and the sparse event code are correct.
- Two equal-priority sources show whether ties resolve to the lower index.
- A higher-priority source in the upper bank shows whether priority overrides index order.
- A raised line with zero priority, and a raised, enabled line with no vector, show whether either can leak into the pending view or the winner.
- Stepping the mask level to the winner's priority and then just below it pins down the strict comparison.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   src_i,
  input  logic [3:0]    mask_lvl_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          line_mode_o,
  output logic          irq_o,
  output logic [3:0]    irq_lvl_o,
  output logic [11:0]   irq_code_o
);
  localparam int NS = 64;

  logic [NS-1:0] en_q, src_q, req;
  logic [3:0]    pri_q [NS];
  logic [6:0]    vec   [NS];
  logic          mode_q;
  logic [3:0]    best_p;
  logic [6:0]    best_v;

  wire [4:0] widx = addr_i[7:3];
  wire       wr   = wr_en_i && (addr_i[2:0] == 3'b000);

  function automatic logic [6:0] vec_of(input int i);
    if (i <= 3)               return 7'(8'h12 + 3 * i);
    if (i >= 4  && i <= 7)    return 7'(8'h40 + i - 4);
    if (i >= 12 && i <= 17)   return 7'(8'h50 + i - 12);
    if (i >= 18 && i <= 22)   return 7'(8'h32 + i - 18);
    if (i >= 32 && i <= 38)   return 7'(8'h20 + i - 32);
    if (i >= 39 && i <= 42)   return 7'(8'h38 + i - 39);
    if (i == 63)              return 7'h2B;
    return 7'h00;
  endfunction

  for (genvar g = 0; g < NS; g++) begin : g_src
    assign vec[g] = vec_of(g);
    assign req[g] = src_q[g] && en_q[g] && (pri_q[g] != 4'd0) && (vec[g] != 7'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      src_q  <= '0;
      mode_q <= 1'b0;
      for (int i = 0; i < NS; i++) pri_q[i] <= 4'd0;
    end else begin
      src_q <= src_i;
      if (wr) begin
        case (widx)
          5'd0:  if (wdata_i[0]) mode_q <= 1'b1;
          5'd1:  if (wdata_i[0]) mode_q <= 1'b0;
          5'd14: en_q[31:0]  <= en_q[31:0]  | wdata_i;
          5'd15: en_q[63:32] <= en_q[63:32] | wdata_i;
          5'd16: en_q[31:0]  <= en_q[31:0]  & ~wdata_i;
          5'd17: en_q[63:32] <= en_q[63:32] & ~wdata_i;
          default: ;
        endcase
      end
      for (int i = 0; i < NS; i++)
        if (wr && widx == 5'(2 + i / 8)) pri_q[i] <= wdata_i[4*(i%8) +: 4];
    end
  end

  always_comb begin
    best_p = 4'd0;
    best_v = 7'd0;
    for (int i = NS - 1; i >= 0; i--)
      if (req[i] && pri_q[i] >= best_p) begin
        best_p = pri_q[i];
        best_v = vec[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      irq_lvl_o  <= 4'd0;
      irq_code_o <= 12'd0;
    end else begin
      irq_o      <= best_p > mask_lvl_i;
      irq_lvl_o  <= best_p;
      irq_code_o <= {best_v, 5'b00000};
    end
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9:
        for (int j = 0; j < 8; j++) rdata_o[4*j +: 4] = pri_q[(int'(widx) - 2) * 8 + j];
      5'd10: rdata_o = src_q[31:0];
      5'd11: rdata_o = src_q[63:32];
      5'd12: rdata_o = req[31:0];
      5'd13: rdata_o = req[63:32];
      5'd14: rdata_o = en_q[31:0];
      5'd15: rdata_o = en_q[63:32];
      default: rdata_o = '0;
    endcase
  end

  assign line_mode_o = mode_q;

  // R9
  irq_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_lvl_o > $past(mask_lvl_i)));

  // R7
  irq_has_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_lvl_o != 4'd0 && irq_code_o != 12'd0));

  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 5'd14) |=> ((en_q[31:0] & $past(wdata_i)) == $past(wdata_i)));

  // R3
  disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 5'd17) |=> ((en_q[63:32] & $past(wdata_i)) == 32'd0));

  // R5
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 5'd0 && wdata_i[0]) |=> line_mode_o);
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic [3:0]  mask_lvl_i = '0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        line_mode_o, irq_o;
  logic [3:0]  irq_lvl_o;
  logic [11:0] irq_code_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_lvl_i(mask_lvl_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .line_mode_o(line_mode_o), .irq_o(irq_o), .irq_lvl_o(irq_lvl_o),
    .irq_code_o(irq_code_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", irq_o, 0);
    chk("R1 mode", line_mode_o, 0);
    rd(8'h70, d); chk("R1 enable lo", d, 0);
    rd(8'h78, d); chk("R1 enable hi", d, 0);
    rd(8'h10, d); chk("R1 prio0", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h70, 32'h0000_00F0);
    wr(8'h70, 32'h0000_0003);
    rd(8'h70, d); chk("R2 set accumulates", d, 32'h0000_00F3);
    wr(8'h78, 32'h8000_0001);
    rd(8'h78, d); chk("R2 upper bank", d, 32'h8000_0001);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(8'h80, 32'h0000_0010);
    rd(8'h70, d); chk("R3 clear one bit", d, 32'h0000_00E3);
    rd(8'h80, d); chk("R3 disable reads zero", d, 0);
    rd(8'h00, d); chk("R3 set reads zero", d, 0);
    rd(8'h08, d); chk("R3 clear reads zero", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(8'h10, 32'h7654_3210);
    rd(8'h10, d); chk("R4 prio reg0", d, 32'h7654_3210);
    wr(8'h48, 32'hA000_0000);
    rd(8'h48, d); chk("R4 prio reg7", d, 32'hA000_0000);
  endtask

  task automatic t_ctrl();
    wr(8'h00, 32'h1);
    chk("R5 set", line_mode_o, 1);
    wr(8'h08, 32'h0);
    chk("R5 zero ignored", line_mode_o, 1);
    wr(8'h08, 32'h1);
    chk("R5 clear", line_mode_o, 0);
  endtask

  task automatic t_raw_and_win();
    logic [31:0] d;
    src_i = 64'h8000_0000_0000_0010;
    settle();
    rd(8'h50, d); chk("R6 raw lo", d, 32'h0000_0010);
    rd(8'h58, d); chk("R6 raw hi", d, 32'h8000_0000);
    rd(8'h60, d); chk("R7 req lo disabled src", d, 0);
    rd(8'h68, d); chk("R7 req hi", d, 32'h8000_0000);
    chk("R8 lvl src63", irq_lvl_o, 4'hA);
    chk("R8 code src63", irq_code_o, 12'h560);
    chk("R9 irq above mask", irq_o, 1);
  endtask

  task automatic t_mask();
    mask_lvl_i = 4'hA;
    settle();
    chk("R9 equal mask blocks", irq_o, 0);
    mask_lvl_i = 4'h9;
    settle();
    chk("R9 mask below", irq_o, 1);
    mask_lvl_i = 4'h0;
  endtask

  task automatic t_arb();
    logic [31:0] d;
    wr(8'h88, 32'h8000_0000);
    wr(8'h10, 32'h0330_0000);
    src_i = 64'h0000_0000_0000_00E0;
    settle();
    rd(8'h60, d); chk("R7 zero prio excluded", d, 32'h0000_0060);
    chk("R8 tie lvl", irq_lvl_o, 4'd3);
    chk("R8 tie lowest index", irq_code_o, 12'h820);
    wr(8'h30, 32'h0000_0005);
    src_i = 64'h0000_0001_0000_00E0;
    settle();
    chk("R8 higher prio wins lvl", irq_lvl_o, 4'd5);
    chk("R8 higher prio wins code", irq_code_o, 12'h400);
  endtask

  task automatic t_novec();
    logic [31:0] d;
    wr(8'h18, 32'h0000_000F);
    wr(8'h70, 32'h0000_0100);
    src_i = 64'h0000_0001_0000_01E0;
    settle();
    rd(8'h60, d); chk("R10 no vector not pending", d, 32'h0000_0060);
    chk("R10 no vector never wins", irq_lvl_o, 4'd5);
    wr(8'h88, 32'h0000_0001);
    wr(8'h80, 32'h0000_00E0);
    settle();
    chk("R10 alone no irq", irq_o, 0);
    chk("R10 alone lvl", irq_lvl_o, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_disable();
    t_prio();
    t_ctrl();
    t_raw_and_win();
    t_mask();
    t_arb();
    t_novec();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule